// File: doc/BRIEF.md
# Ownership Snoop Controller with Read-Broadcast Refill

This block keeps the coherence state for every line of a small direct-mapped cache in a shared-bus multiprocessor. Each line carries a tag, a tag-held flag and one of four ownership states. The states are Invalid, Valid, Shared Dirty and Dirty. A processor write to a line that other caches may also hold first wins the bus with an invalidate. After that, the writer owns the line and writes to it without using the bus again. A Dirty line that is read by another cache hands over its data and drops to Shared Dirty. It keeps the duty to write the line back. Any line with an owning state is written back before it is replaced.

The block also refills lines by read-broadcast. An invalidation clears only the state and leaves the tag in place. When another cache later reads the same address on the bus, this controller picks the data up from the bus and the line becomes Valid again. Each invalidation therefore costs at most one miss across all the caches that lost the line. The price is snoop work in the tag and state array. Every snoop takes a lookup cycle and then an acknowledge cycle, and the processor is locked out of the cache for both. The data array sits outside the block and is written through the fill port. Bus arbitration also sits outside the block.

Top module: `rb_own_snoop_ctl`

## Requirements
- R1: After synchronous reset every line is Invalid and holds no tag. The outputs cpu_done, cpu_stall, bus_req, snp_ack, snp_supply and fill_we are low, and the first read to any address misses. Bus request codes on bus_cmd: 0 read, 1 read-exclusive, 2 invalidate, 3 write-back.
- R2: An address splits into an index (its low INDEX_W bits) and a tag (the remaining upper bits). A processor read whose tag matches a line in Valid, Shared Dirty or Dirty raises cpu_done in the same cycle and raises no bus request.
- R3: A read miss requests code 0 with the request address. In the grant cycle, fill_we is high, fill_idx equals the index and fill_data equals bus_rdata. The line is then Valid.
- R4: A write to a Valid or Shared Dirty line requests code 2. After the grant, the line is Dirty, and every later write to it completes with no bus request.
- R5: A write miss requests code 1. In the grant cycle the line is filled from bus_rdata and becomes Dirty.
- R6: A miss whose indexed line holds another tag in Shared Dirty or Dirty first requests code 3 with the old tag's address, then the miss request. A Valid victim produces no write-back.
- R7: While snp_valid is high and in the following acknowledge cycle, a pending processor request sees cpu_stall high, cpu_done low and bus_req low. The request is served in the first free cycle. A snoop that arrives in the same cycle as a processor request wins.
- R8: snp_ack is high exactly in the cycle after snp_valid. Snoops are at least two cycles apart. Snoop codes on snp_cmd: 0 read, 1 read-exclusive, 2 invalidate.
- R9: A snoop read that hits a Dirty or Shared Dirty line raises snp_supply in the acknowledge cycle and leaves the line Shared Dirty. A Valid line is left untouched.
- R10: A snoop read-exclusive or invalidate that hits a valid line makes it Invalid and keeps the tag. A read-exclusive that hits Dirty or Shared Dirty also raises snp_supply. A pending upgrade on a line invalidated this way turns into a read-exclusive request.
- R11: A snoop read to an Invalid line whose held tag matches writes snp_data through the fill port in the acknowledge cycle. The line becomes Valid, so the next processor read hits.
- R12: A snoop read whose tag differs from the held tag, or that targets a line never filled, causes no fill and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request pending, held until cpu_done |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Processor address |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request locked out by snoop activity |
| snp_valid | input | 1 | Another cache's bus transaction is present |
| snp_cmd | input | 2 | Snoop command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Data carried by the snooped bus read |
| snp_ack | output | 1 | Snoop acknowledge cycle |
| snp_supply | output | 1 | This cache provides the line's data |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Requested bus command code |
| bus_addr | output | ADDR_W | Requested bus address |
| bus_gnt | input | 1 | Requested transaction completes this cycle |
| bus_rdata | input | DATA_W | Data returned for a read or read-exclusive |
| fill_we | output | 1 | Write strobe to the external data array |
| fill_idx | output | INDEX_W | Line index written |
| fill_data | output | DATA_W | Data written to the line |

## Verification
The bench sweeps all four starting states of one line against the three snoop commands, with matching and non-matching tags. For each case it checks the supply strobe and the capture strobe, and it probes the resulting state. A design that lost the tag on invalidation would miss on the later read instead of capturing. A design that captured on a tag mismatch would corrupt an unrelated line. Directed sequences cover the harder paths. The first is a Shared Dirty victim, which must be written back, while a Valid victim must not be. The second is a write to a Shared Dirty line, which needs an invalidate where a controller that confused it with Dirty would skip the bus. The third is a snoop that collides with a processor request. The last is an upgrade invalidated before its grant, which would end up Dirty on stale data if it were not reissued as read-exclusive.

// File: rtl/rb_own_pkg.sv
package rb_own_pkg;

    typedef enum logic [1:0] {
        LS_INV     = 2'd0,
        LS_VALID   = 2'd1,
        LS_SHDIRTY = 2'd2,
        LS_DIRTY   = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        SN_READ  = 2'd0,
        SN_READX = 2'd1,
        SN_INVAL = 2'd2,
        SN_RSVD  = 2'd3
    } snp_cmd_e;

    typedef enum logic [1:0] {
        BQ_READ  = 2'd0,
        BQ_READX = 2'd1,
        BQ_INVAL = 2'd2,
        BQ_WBACK = 2'd3
    } bus_cmd_e;

    typedef struct packed {
        line_st_e nxt;
        logic     upd;
        logic     supply;
        logic     capture;
    } snp_act_t;

    function automatic logic holds_dirty(input line_st_e s);
        return (s == LS_SHDIRTY) || (s == LS_DIRTY);
    endfunction

    // Reaction of one line to another cache's bus transaction.
    // match already includes the tag-held flag.
    function automatic snp_act_t snoop_react(input line_st_e cur,
                                             input snp_cmd_e cmd,
                                             input logic     match);
        snp_act_t a;
        a.nxt     = cur;
        a.upd     = 1'b0;
        a.supply  = 1'b0;
        a.capture = 1'b0;
        if (match) begin
            case (cmd)
                SN_READ: begin
                    if (cur == LS_INV) begin
                        a.nxt     = LS_VALID;
                        a.upd     = 1'b1;
                        a.capture = 1'b1;
                    end else if (holds_dirty(cur)) begin
                        a.nxt    = LS_SHDIRTY;
                        a.upd    = 1'b1;
                        a.supply = 1'b1;
                    end
                end
                SN_READX: begin
                    a.supply = holds_dirty(cur);
                    if (cur != LS_INV) begin
                        a.nxt = LS_INV;
                        a.upd = 1'b1;
                    end
                end
                SN_INVAL: begin
                    if (cur != LS_INV) begin
                        a.nxt = LS_INV;
                        a.upd = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/rb_line_store.sv
module rb_line_store
    import rb_own_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] pa_idx,
    output logic [TAG_W-1:0]   pa_tag,
    output logic               pa_held,
    output line_st_e           pa_st,
    input  logic [INDEX_W-1:0] pb_idx,
    output logic [TAG_W-1:0]   pb_tag,
    output logic               pb_held,
    output line_st_e           pb_st,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               wr_held,
    input  line_st_e           wr_st
);
    localparam int LINES = 1 << INDEX_W;

    logic [TAG_W-1:0] tag_a  [LINES];
    logic             held_a [LINES];
    line_st_e         st_a   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        logic             held_q;
        line_st_e         st_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q  <= '0;
                held_q <= 1'b0;
                st_q   <= LS_INV;
            end else if (wr_en && (wr_idx == INDEX_W'(g))) begin
                tag_q  <= wr_tag;
                held_q <= wr_held;
                st_q   <= wr_st;
            end
        end

        assign tag_a[g]  = tag_q;
        assign held_a[g] = held_q;
        assign st_a[g]   = st_q;
    end

    assign pa_tag  = tag_a[pa_idx];
    assign pa_held = held_a[pa_idx];
    assign pa_st   = st_a[pa_idx];
    assign pb_tag  = tag_a[pb_idx];
    assign pb_held = held_a[pb_idx];
    assign pb_st   = st_a[pb_idx];

endmodule

// File: rtl/rb_cpu_path.sv
module rb_cpu_path
    import rb_own_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 8
) (
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      lock,
    input  logic [ADDR_W-INDEX_W-1:0] look_tag,
    input  logic                      look_held,
    input  line_st_e                  look_st,
    input  logic                      bus_gnt,
    input  logic [DATA_W-1:0]         bus_rdata,
    output logic                      done,
    output logic                      stall,
    output logic                      bus_req,
    output bus_cmd_e                  bus_cmd,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      wr_en,
    output logic [ADDR_W-INDEX_W-1:0] wr_tag,
    output logic                      wr_held,
    output line_st_e                  wr_st,
    output logic                      fill_we,
    output logic [DATA_W-1:0]         fill_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic               tag_eq;
    logic               hit;
    logic               victim_dirty;
    logic               active;
    logic               granted;

    assign req_idx      = req_addr[INDEX_W-1:0];
    assign req_tag      = req_addr[ADDR_W-1:INDEX_W];
    assign tag_eq       = look_held && (look_tag == req_tag);
    assign hit          = tag_eq && (look_st != LS_INV);
    assign victim_dirty = look_held && !tag_eq && holds_dirty(look_st);
    assign active       = req_valid && !lock;
    assign stall        = req_valid && lock;

    // The request is re-evaluated against the current line every free
    // cycle, so a snoop that changes the line between cycles redirects it.
    always_comb begin
        done    = 1'b0;
        bus_req = 1'b0;
        bus_cmd = BQ_READ;
        if (active) begin
            if (hit && (!req_write || (look_st == LS_DIRTY))) begin
                done = 1'b1;
            end else begin
                bus_req = 1'b1;
                if (hit)               bus_cmd = BQ_INVAL;
                else if (victim_dirty) bus_cmd = BQ_WBACK;
                else if (req_write)    bus_cmd = BQ_READX;
                else                   bus_cmd = BQ_READ;
            end
        end
    end

    assign bus_addr = (bus_cmd == BQ_WBACK) ? {look_tag, req_idx} : req_addr;
    assign granted  = bus_req && bus_gnt;

    always_comb begin
        wr_en     = 1'b0;
        wr_tag    = look_tag;
        wr_held   = look_held;
        wr_st     = look_st;
        fill_we   = 1'b0;
        fill_data = bus_rdata;
        if (granted) begin
            wr_en = 1'b1;
            case (bus_cmd)
                BQ_WBACK: begin
                    wr_held = 1'b1;
                    wr_st   = LS_INV;
                end
                BQ_READ: begin
                    wr_tag  = req_tag;
                    wr_held = 1'b1;
                    wr_st   = LS_VALID;
                    fill_we = 1'b1;
                end
                BQ_READX: begin
                    wr_tag  = req_tag;
                    wr_held = 1'b1;
                    wr_st   = LS_DIRTY;
                    fill_we = 1'b1;
                end
                default: begin
                    wr_held = 1'b1;
                    wr_st   = LS_DIRTY;
                end
            endcase
        end
    end

endmodule

// File: rtl/rb_snoop_pipe.sv
module rb_snoop_pipe
    import rb_own_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      snp_valid,
    input  logic [1:0]                snp_cmd,
    input  logic [ADDR_W-1:0]         snp_addr,
    input  logic [DATA_W-1:0]         snp_data,
    input  logic [ADDR_W-INDEX_W-1:0] look_tag,
    input  logic                      look_held,
    input  line_st_e                  look_st,
    output logic                      lock,
    output logic                      ack,
    output logic                      supply,
    output logic                      wr_en,
    output logic [INDEX_W-1:0]        wr_idx,
    output logic [ADDR_W-INDEX_W-1:0] wr_tag,
    output line_st_e                  wr_st,
    output logic                      fill_we,
    output logic [DATA_W-1:0]         fill_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    // Holding stage: lookup result and broadcast data from the snoop cycle.
    logic               h_vld;
    snp_cmd_e           h_cmd;
    logic [INDEX_W-1:0] h_idx;
    logic [TAG_W-1:0]   h_tag;
    logic [DATA_W-1:0]  h_data;
    line_st_e           h_st;
    logic               h_match;
    snp_act_t           act;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_vld   <= 1'b0;
            h_cmd   <= SN_READ;
            h_idx   <= '0;
            h_tag   <= '0;
            h_data  <= '0;
            h_st    <= LS_INV;
            h_match <= 1'b0;
        end else begin
            h_vld <= snp_valid;
            if (snp_valid) begin
                h_cmd   <= snp_cmd_e'(snp_cmd);
                h_idx   <= snp_addr[INDEX_W-1:0];
                h_tag   <= snp_addr[ADDR_W-1:INDEX_W];
                h_data  <= snp_data;
                h_st    <= look_st;
                h_match <= look_held && (look_tag == snp_addr[ADDR_W-1:INDEX_W]);
            end
        end
    end

    assign act       = snoop_react(h_st, h_cmd, h_match);
    assign lock      = snp_valid || h_vld;
    assign ack       = h_vld;
    assign supply    = h_vld && act.supply;
    assign wr_en     = h_vld && act.upd;
    assign wr_idx    = h_idx;
    assign wr_tag    = h_tag;
    assign wr_st     = act.nxt;
    assign fill_we   = h_vld && act.capture;
    assign fill_data = h_data;

endmodule

// File: rtl/rb_own_snoop_ctl.sv
module rb_own_snoop_ctl
    import rb_own_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req_valid,
    input  logic               cpu_req_write,
    input  logic [ADDR_W-1:0]  cpu_req_addr,
    output logic               cpu_done,
    output logic               cpu_stall,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [ADDR_W-1:0]  snp_addr,
    input  logic [DATA_W-1:0]  snp_data,
    output logic               snp_ack,
    output logic               snp_supply,
    output logic               bus_req,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_gnt,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               fill_we,
    output logic [INDEX_W-1:0] fill_idx,
    output logic [DATA_W-1:0]  fill_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [TAG_W-1:0]  ca_tag, sb_tag;
    logic              ca_held, sb_held;
    line_st_e          ca_st, sb_st;

    logic              lock;
    bus_cmd_e          cp_cmd;
    logic              cp_wr_en, cp_wr_held, cp_fill_we;
    logic [TAG_W-1:0]  cp_wr_tag;
    line_st_e          cp_wr_st;
    logic [DATA_W-1:0] cp_fill_data;

    logic               sn_wr_en, sn_fill_we;
    logic [INDEX_W-1:0] sn_wr_idx;
    logic [TAG_W-1:0]   sn_wr_tag;
    line_st_e           sn_wr_st;
    logic [DATA_W-1:0]  sn_fill_data;

    logic               st_wr_en, st_wr_held;
    logic [INDEX_W-1:0] st_wr_idx;
    logic [TAG_W-1:0]   st_wr_tag;
    line_st_e           st_wr_st;

    rb_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .pa_idx  (cpu_req_addr[INDEX_W-1:0]),
        .pa_tag  (ca_tag),
        .pa_held (ca_held),
        .pa_st   (ca_st),
        .pb_idx  (snp_addr[INDEX_W-1:0]),
        .pb_tag  (sb_tag),
        .pb_held (sb_held),
        .pb_st   (sb_st),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_tag  (st_wr_tag),
        .wr_held (st_wr_held),
        .wr_st   (st_wr_st)
    );

    rb_snoop_pipe #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_snoop (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_addr  (snp_addr),
        .snp_data  (snp_data),
        .look_tag  (sb_tag),
        .look_held (sb_held),
        .look_st   (sb_st),
        .lock      (lock),
        .ack       (snp_ack),
        .supply    (snp_supply),
        .wr_en     (sn_wr_en),
        .wr_idx    (sn_wr_idx),
        .wr_tag    (sn_wr_tag),
        .wr_st     (sn_wr_st),
        .fill_we   (sn_fill_we),
        .fill_data (sn_fill_data)
    );

    rb_cpu_path #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_cpu (
        .req_valid (cpu_req_valid),
        .req_write (cpu_req_write),
        .req_addr  (cpu_req_addr),
        .lock      (lock),
        .look_tag  (ca_tag),
        .look_held (ca_held),
        .look_st   (ca_st),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .done      (cpu_done),
        .stall     (cpu_stall),
        .bus_req   (bus_req),
        .bus_cmd   (cp_cmd),
        .bus_addr  (bus_addr),
        .wr_en     (cp_wr_en),
        .wr_tag    (cp_wr_tag),
        .wr_held   (cp_wr_held),
        .wr_st     (cp_wr_st),
        .fill_we   (cp_fill_we),
        .fill_data (cp_fill_data)
    );

    assign bus_cmd = cp_cmd;

    // The snoop side owns the array whenever it is active; the processor
    // side only writes in unlocked cycles, so the two never collide.
    always_comb begin
        if (sn_wr_en) begin
            st_wr_en   = 1'b1;
            st_wr_idx  = sn_wr_idx;
            st_wr_tag  = sn_wr_tag;
            st_wr_held = 1'b1;
            st_wr_st   = sn_wr_st;
        end else begin
            st_wr_en   = cp_wr_en;
            st_wr_idx  = cpu_req_addr[INDEX_W-1:0];
            st_wr_tag  = cp_wr_tag;
            st_wr_held = cp_wr_held;
            st_wr_st   = cp_wr_st;
        end
    end

    always_comb begin
        if (sn_fill_we) begin
            fill_we   = 1'b1;
            fill_idx  = sn_wr_idx;
            fill_data = sn_fill_data;
        end else begin
            fill_we   = cp_fill_we;
            fill_idx  = cpu_req_addr[INDEX_W-1:0];
            fill_data = cp_fill_data;
        end
    end

endmodule

// File: rtl/rb_own_snoop_ctl_chk.sv
module rb_own_snoop_ctl_chk #(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_req_valid,
    input logic               cpu_req_write,
    input logic [ADDR_W-1:0]  cpu_req_addr,
    input logic               cpu_done,
    input logic               cpu_stall,
    input logic               snp_valid,
    input logic [1:0]         snp_cmd,
    input logic [ADDR_W-1:0]  snp_addr,
    input logic [DATA_W-1:0]  snp_data,
    input logic               snp_ack,
    input logic               snp_supply,
    input logic               bus_req,
    input logic [1:0]         bus_cmd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_gnt,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               fill_we,
    input logic [INDEX_W-1:0] fill_idx,
    input logic [DATA_W-1:0]  fill_data
);
    a_r8_ack_after_snoop: assert property (@(posedge clk) disable iff (rst)
        snp_valid |=> snp_ack);

    a_r8_ack_has_cause: assert property (@(posedge clk) disable iff (rst)
        snp_ack |-> $past(snp_valid));

    a_r7_locked_quiet: assert property (@(posedge clk) disable iff (rst)
        (snp_valid || snp_ack) |-> (!cpu_done && !bus_req));

    a_r7_stall_on_collision: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && snp_valid) |-> cpu_stall);

    a_r9_supply_in_ack: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> snp_ack);

    a_r11_fill_source: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> (snp_ack || (bus_req && bus_gnt)));

    a_r2_done_no_bus: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !bus_req);

    a_r3_refill_data: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && (bus_cmd == 2'd0 || bus_cmd == 2'd1))
            |-> (fill_we && fill_data == bus_rdata && fill_idx == cpu_req_addr[INDEX_W-1:0]));

endmodule

bind rb_own_snoop_ctl rb_own_snoop_ctl_chk #(
    .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/rb_own_snoop_ctl_tb.sv
`timescale 1ns/1ps
module rb_own_snoop_ctl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_req_valid, cpu_req_write;
    logic [7:0] cpu_req_addr;
    logic       cpu_done, cpu_stall;
    logic       snp_valid;
    logic [1:0] snp_cmd;
    logic [7:0] snp_addr, snp_data;
    logic       snp_ack, snp_supply;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr;
    logic       bus_gnt;
    logic [7:0] bus_rdata;
    logic       fill_we;
    logic [1:0] fill_idx;
    logic [7:0] fill_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rb_own_snoop_ctl u_dut (.*);

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = 0;
        snp_valid = 0; snp_cmd = 0; snp_addr = 0; snp_data = 0;
        bus_gnt = 0; bus_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input logic [7:0] d,
                         output bit s, output bit f, output logic [7:0] fd,
                         output logic [1:0] fi, output bit a0, output bit a1);
        snp_valid = 1; snp_cmd = cmd; snp_addr = a; snp_data = d;
        #1 a0 = snp_ack;
        @(negedge clk);
        snp_valid = 0;
        #1;
        a1 = snp_ack; s = snp_supply; f = fill_we; fd = fill_data; fi = fill_idx;
        @(negedge clk);
    endtask

    task automatic cpu_op(input bit w, input logic [7:0] a, output int nb,
                          output logic [1:0] c0, output logic [7:0] ad0,
                          output logic [1:0] c1, output logic [7:0] ad1,
                          output bit fok, output bit dn);
        nb = 0; c0 = 0; ad0 = 0; c1 = 0; ad1 = 0; fok = 1; dn = 0;
        cpu_req_valid = 1; cpu_req_write = w; cpu_req_addr = a;
        for (int k = 0; k < 12; k++) begin
            #1;
            if (cpu_done) begin
                dn = 1;
                break;
            end
            if (bus_req) begin
                if (nb == 0) begin c0 = bus_cmd; ad0 = bus_addr; end
                else begin c1 = bus_cmd; ad1 = bus_addr; end
                nb++;
                bus_gnt = 1; bus_rdata = a ^ 8'h5A;
                #1;
                if (bus_cmd == 2'd0 || bus_cmd == 2'd1)
                    fok &= fill_we && (fill_data == (a ^ 8'h5A)) && (fill_idx == a[1:0]);
            end
            @(negedge clk);
            bus_gnt = 0;
        end
        @(negedge clk);
        cpu_req_valid = 0;
    endtask

    int         nb;
    logic [1:0] c0, c1, fi;
    logic [7:0] ad0, ad1, fd;
    bit         fok, dn, s, f, a0, a1;

    initial begin
        #(5.0 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R1", "bus_req idle", bus_req, 0);
        chk("R1", "snp_ack idle", snp_ack, 0);
        chk("R1", "snp_supply idle", snp_supply, 0);
        chk("R1", "fill_we idle", fill_we, 0);
        chk("R1", "cpu_stall idle", cpu_stall, 0);
        chk("R1", "cpu_done idle", cpu_done, 0);
        @(negedge clk);

        // R3: first read misses with a read request and refills
        cpu_op(0, 8'h14, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R3", "miss requests", nb, 1);
        chk("R3", "miss cmd", c0, 0);
        chk("R3", "miss addr", ad0, 8'h14);
        chk("R3", "refill strobe", fok, 1);
        chk("R3", "completes", dn, 1);
        cpu_op(0, 8'h14, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R2", "read hit bus", nb, 0);
        chk("R2", "read hit done", dn, 1);

        // R4: upgrade then silent writes
        cpu_op(1, 8'h14, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R4", "upgrade count", nb, 1);
        chk("R4", "upgrade cmd", c0, 2);
        cpu_op(1, 8'h14, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R4", "dirty write bus", nb, 0);

        // R9: dirty line read by another cache
        snoop(2'd0, 8'h14, 8'h00, s, f, fd, fi, a0, a1);
        chk("R8", "ack not in snoop cycle", a0, 0);
        chk("R8", "ack next cycle", a1, 1);
        chk("R9", "dirty supplies", s, 1);
        chk("R9", "no capture on owner", f, 0);
        cpu_op(1, 8'h14, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R9", "shared dirty needs invalidate", c0, 2);
        chk("R9", "shared dirty req count", nb, 1);
        snoop(2'd0, 8'h14, 8'h00, s, f, fd, fi, a0, a1);
        chk("R9", "dirty supplies again", s, 1);
        snoop(2'd0, 8'h14, 8'h00, s, f, fd, fi, a0, a1);
        chk("R9", "shared dirty keeps supplying", s, 1);

        // R6: shared dirty victim written back first
        cpu_op(0, 8'h24, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R6", "victim req count", nb, 2);
        chk("R6", "writeback cmd", c0, 3);
        chk("R6", "writeback addr", ad0, 8'h14);
        chk("R6", "then read cmd", c1, 0);
        chk("R6", "then read addr", ad1, 8'h24);
        cpu_op(0, 8'h34, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R6", "valid victim no writeback", nb, 1);
        chk("R6", "valid victim read", c0, 0);

        // R5: write miss
        cpu_op(1, 8'h41, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R5", "write miss cmd", c0, 1);
        chk("R5", "write miss count", nb, 1);
        chk("R5", "write miss fill", fok, 1);
        cpu_op(1, 8'h41, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R5", "dirty after write miss", nb, 0);

        // R10: read-exclusive from another cache
        snoop(2'd1, 8'h41, 8'h00, s, f, fd, fi, a0, a1);
        chk("R10", "readx on dirty supplies", s, 1);
        cpu_op(0, 8'h41, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R10", "invalidated read misses", nb, 1);
        chk("R10", "invalidated read cmd", c0, 0);

        // R11: invalidate then capture from a bus read
        snoop(2'd2, 8'h41, 8'h00, s, f, fd, fi, a0, a1);
        chk("R10", "invalidate no supply", s, 0);
        chk("R10", "invalidate no fill", f, 0);
        snoop(2'd0, 8'h41, 8'hA5, s, f, fd, fi, a0, a1);
        chk("R11", "capture strobe", f, 1);
        chk("R11", "capture data", fd, 8'hA5);
        chk("R11", "capture index", fi, 1);
        chk("R11", "capture no supply", s, 0);
        cpu_op(0, 8'h41, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R11", "read after capture hits", nb, 0);

        // R12: no capture without a held matching tag
        snoop(2'd0, 8'h42, 8'h11, s, f, fd, fi, a0, a1);
        chk("R12", "never filled no capture", f, 0);
        cpu_op(0, 8'h42, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R12", "never filled still misses", nb, 1);
        snoop(2'd2, 8'h42, 8'h00, s, f, fd, fi, a0, a1);
        snoop(2'd0, 8'h82, 8'h22, s, f, fd, fi, a0, a1);
        chk("R12", "tag mismatch no capture", f, 0);
        cpu_op(0, 8'h82, nb, c0, ad0, c1, ad1, fok, dn);
        chk("R12", "mismatch line still misses", nb, 1);

        // R7: snoop and processor collide
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 8'h82;
        snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h82; snp_data = 8'h00;
        #1;
        chk("R7", "stall in snoop cycle", cpu_stall, 1);
        chk("R7", "no done in snoop cycle", cpu_done, 0);
        chk("R7", "no bus in snoop cycle", bus_req, 0);
        @(negedge clk); snp_valid = 0; #1;
        chk("R7", "stall in ack cycle", cpu_stall, 1);
        chk("R7", "no done in ack cycle", cpu_done, 0);
        @(negedge clk); #1;
        chk("R7", "served after lockout", cpu_done, 1);
        chk("R7", "no stall after lockout", cpu_stall, 0);
        @(negedge clk); cpu_req_valid = 0;

        // R10: upgrade invalidated before its grant
        cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = 8'h82;
        #1;
        chk("R4", "upgrade requested", bus_cmd, 2);
        chk("R4", "upgrade bus_req", bus_req, 1);
        @(negedge clk);
        snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h82;
        #1 chk("R7", "stall under invalidate", cpu_stall, 1);
        @(negedge clk); snp_valid = 0;
        #1 chk("R7", "stall in ack", cpu_stall, 1);
        @(negedge clk); #1;
        chk("R10", "lost upgrade becomes readx", bus_cmd, 1);
        chk("R10", "lost upgrade requests", bus_req, 1);
        bus_gnt = 1; bus_rdata = 8'h77;
        @(negedge clk); bus_gnt = 0; #1;
        chk("R5", "done after readx", cpu_done, 1);
        @(negedge clk); cpu_req_valid = 0;

        // Sweep: start state x snoop command x tag match on index 3
        for (int st = 0; st < 4; st++) begin
            for (int cm = 0; cm < 3; cm++) begin
                for (int m = 0; m < 2; m++) begin
                    int         end_st;
                    bit         exp_s, exp_f;
                    logic [7:0] sa;
                    do_reset();
                    case (st)
                        0: begin
                            cpu_op(0, 8'h0F, nb, c0, ad0, c1, ad1, fok, dn);
                            snoop(2'd2, 8'h0F, 8'h00, s, f, fd, fi, a0, a1);
                        end
                        1: cpu_op(0, 8'h0F, nb, c0, ad0, c1, ad1, fok, dn);
                        2: begin
                            cpu_op(1, 8'h0F, nb, c0, ad0, c1, ad1, fok, dn);
                            snoop(2'd0, 8'h0F, 8'h00, s, f, fd, fi, a0, a1);
                        end
                        default: cpu_op(1, 8'h0F, nb, c0, ad0, c1, ad1, fok, dn);
                    endcase
                    sa = (m == 1) ? 8'h0F : 8'h1F;
                    exp_s = (m == 1) && (st >= 2) && (cm <= 1);
                    exp_f = (m == 1) && (st == 0) && (cm == 0);
                    // end class: 0 invalid-held, 1 valid, 2 owner
                    if (m == 0) end_st = (st >= 2) ? 2 : st;
                    else if (cm == 0) end_st = (st >= 2) ? 2 : 1;
                    else end_st = 0;
                    snoop(cm[1:0], sa, 8'hC3, s, f, fd, fi, a0, a1);
                    chk("R8", "sweep ack", a1, 1);
                    chk((cm == 0) ? "R9" : "R10", "sweep supply", s, exp_s);
                    chk((m == 0) ? "R12" : "R11", "sweep capture", f, exp_f);
                    snoop(2'd0, 8'h0F, 8'h3C, s, f, fd, fi, a0, a1);
                    chk("R9", "probe supply", s, (end_st == 2));
                    chk("R11", "probe capture", f, (end_st == 0));
                    cpu_op(0, 8'h0F, nb, c0, ad0, c1, ad1, fok, dn);
                    chk("R2", "probe read hit", nb, 0);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule